// File: doc/BRIEF.md
# Interval Timer with Buffered Compare

This block is a 16-bit up-counting interval timer with two compare values, loaded through a narrow byte-wide write bus. Compare value 1 sets the period: when the running counter reaches it, the counter returns to zero on the next clock. Compare value 0 marks a point inside that period. Each compare value raises its own match output when the running counter equals it.

Compare value 0 can be double buffered. When buffering is off, a completed write to compare 0 loads the active value and a shadow copy together. When buffering is on, the write lands only in the shadow. The shadow then moves into the active compare 0 at the next compare 1 match. This lets software queue the next mid-period value without disturbing the current period.

To load a value, software writes the low byte first and then the high byte. The low byte is held in a staging register. The whole 16-bit value takes effect on the high-byte write. The compare values cannot be read back.

Top module: `dbl_timer_cmp`

## Requirements
- R1: After reset, the counter output is 0 and both match outputs are low. Compare values, shadow and staging bytes reset to 0.
- R2: While `runEn` is 1, the counter increments by one on each clock. While `runEn` is 0, it holds its value.
- R3: When `runEn` is 1 and the counter equals compare 1, the counter is 0 after the next clock. The period is therefore compare 1 plus one clocks.
- R4: `match1` is high exactly when `runEn` is 1 and the counter equals compare 1.
- R5: `match0` is high exactly when `runEn` is 1 and the counter equals compare 0.
- R6: Write address 0 is the compare 0 low byte and address 1 its high byte. Address 2 is the compare 1 low byte and address 3 its high byte. A low-byte write only stages the byte. The compare value changes only on the high-byte write, to {high byte, staged low byte}.
- R7: With `bufEn` at 0, a high-byte write to compare 0 loads both the active compare 0 and the shadow. The new value is in effect from the next clock.
- R8: With `bufEn` at 1, a high-byte write to compare 0 loads only the shadow. The active compare 0 is unchanged until a transfer.
- R9: With `bufEn` at 1, the cycle where `runEn` is 1 and the counter equals compare 1 copies the shadow, as it was before that clock, into the active compare 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Byte write strobe |
| wrAddr | input | 2 | Byte write address (0..3) |
| wrData | input | 8 | Byte write data |
| runEn | input | 1 | Counter run control |
| bufEn | input | 1 | Double-buffer enable for compare 0 |
| match0 | output | 1 | Compare 0 match pulse |
| match1 | output | 1 | Compare 1 match pulse |
| count | output | 16 | Current counter value |

## Verification
The hardest case to reach is a buffered write that sits in the shadow while the old compare 0 stays active. The only evidence is where `match0` fires, before and after a compare 1 match. The stimulus first sets a known period with buffering off. It then turns buffering on and writes a new compare 0 partway through a period. The scoreboard checks that the old match point still fires in that period and the new point fires only after the wrap. A lone low-byte write to compare 1 is also issued, to show that the period stays unchanged until the high byte arrives.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  typedef struct packed {
    logic stageLo0;
    logic stageLo1;
    logic loadAct0;
    logic loadShd0;
    logic loadCmp1;
    logic cntInc;
    logic cntClr;
    logic xfer;
  } dtc_strb_t;
endpackage

// File: rtl/dtc_control.sv
module dtc_control
  import dtc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic             runEn,
  input  logic             bufEn,
  input  logic             eq0,
  input  logic             eq1,
  input  logic [CNT_W-1:0] cntVal,
  output dtc_strb_t        strb,
  output logic             match0,
  output logic             match1
);
  logic hiWr0;

  always_comb begin
    hiWr0         = wrEn && (wrAddr == 2'd1);
    strb.stageLo0 = wrEn && (wrAddr == 2'd0);
    strb.stageLo1 = wrEn && (wrAddr == 2'd2);
    strb.loadCmp1 = wrEn && (wrAddr == 2'd3);
    strb.loadShd0 = hiWr0;
    strb.loadAct0 = hiWr0 && !bufEn;
    strb.cntClr   = runEn && eq1;
    strb.cntInc   = runEn && !eq1;
    strb.xfer     = bufEn && runEn && eq1;
    match0        = runEn && eq0;
    match1        = runEn && eq1;
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !eq1) |=> cntVal == CNT_W'($past(cntVal) + 1'b1));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> $stable(cntVal));

  // R3
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    match1 |=> cntVal == '0);
endmodule

// File: rtl/dtc_datapath.sv
module dtc_datapath
  import dtc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dtc_strb_t        strb,
  input  logic [CNT_W/2-1:0] wrByte,
  output logic [CNT_W-1:0] cntVal,
  output logic             eq0,
  output logic             eq1
);
  localparam int HALF = CNT_W / 2;

  logic [HALF-1:0]  lo0, lo1;
  logic [CNT_W-1:0] cmp0Act, cmp0Shd, cmp1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lo0     <= '0;
      lo1     <= '0;
      cmp0Act <= '0;
      cmp0Shd <= '0;
      cmp1    <= '0;
      cntVal  <= '0;
    end else begin
      if (strb.stageLo0) lo0 <= wrByte;
      if (strb.stageLo1) lo1 <= wrByte;
      if (strb.loadShd0) cmp0Shd <= {wrByte, lo0};
      if (strb.loadAct0)  cmp0Act <= {wrByte, lo0};
      else if (strb.xfer) cmp0Act <= cmp0Shd;
      if (strb.loadCmp1) cmp1 <= {wrByte, lo1};
      if (strb.cntClr)      cntVal <= '0;
      else if (strb.cntInc) cntVal <= cntVal + 1'b1;
    end
  end

  always_comb begin
    eq0 = (cntVal == cmp0Act);
    eq1 = (cntVal == cmp1);
  end

  // R8
  act0_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadAct0 && !strb.xfer) |=> $stable(cmp0Act));

  // R9
  shadow_xfer_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.xfer |=> cmp0Act == $past(cmp0Shd));

  // R6
  cmp1_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadCmp1 |=> $stable(cmp1));
endmodule

// File: rtl/dbl_timer_cmp.sv
module dbl_timer_cmp
  import dtc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         wrAddr,
  input  logic [CNT_W/2-1:0] wrData,
  input  logic               runEn,
  input  logic               bufEn,
  output logic               match0,
  output logic               match1,
  output logic [CNT_W-1:0]   count
);
  dtc_strb_t strb;
  logic      eq0, eq1;

  dtc_control #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .runEn(runEn), .bufEn(bufEn), .eq0(eq0), .eq1(eq1),
    .cntVal(count), .strb(strb), .match0(match0), .match1(match1)
  );

  dtc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrByte(wrData),
    .cntVal(count), .eq0(eq0), .eq1(eq1)
  );
endmodule

// File: tb/dbl_timer_cmp_test.sv
module dbl_timer_cmp_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        runEn = 1'b0;
  logic        bufEn = 1'b0;
  logic        match0, match1;
  logic [15:0] count;

  int compared = 0;
  int mismatched = 0;
  string phase = "R1";

  typedef struct {
    logic [15:0] cnt;
    logic [15:0] c0;
    logic [15:0] c1;
    string       ph;
  } item_t;
  item_t expQ[$];

  always #10 clk = ~clk;

  dbl_timer_cmp uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .runEn(runEn), .bufEn(bufEn), .match0(match0), .match1(match1), .count(count)
  );

  // reference model, advanced on each rising edge
  logic [15:0] mCnt, mC0, mShd, mC1;
  logic [7:0]  mLo0, mLo1;
  logic        mEq1, mXf;
  item_t       pushIt;

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = '0; mC0 = '0; mShd = '0; mC1 = '0; mLo0 = '0; mLo1 = '0;
    end else begin
      mEq1 = (mCnt == mC1);
      mXf  = bufEn && runEn && mEq1;
      if (mXf) mC0 = mShd;
      if (runEn) mCnt = mEq1 ? 16'd0 : mCnt + 16'd1;
      if (wrEn) begin
        case (wrAddr)
          2'd0: mLo0 = wrData;
          2'd1: begin
            mShd = {wrData, mLo0};
            if (!bufEn) mC0 = {wrData, mLo0};
          end
          2'd2: mLo1 = wrData;
          default: mC1 = {wrData, mLo1};
        endcase
      end
    end
    pushIt.cnt = mCnt; pushIt.c0 = mC0; pushIt.c1 = mC1; pushIt.ph = phase;
    expQ.push_back(pushIt);
  end

  // monitor: compare between edges
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      item_t it;
      logic  e0, e1;
      it = expQ.pop_front();
      e0 = runEn && (it.cnt == it.c0);
      e1 = runEn && (it.cnt == it.c1);
      compared++;
      if (count !== it.cnt || match0 !== e0 || match1 !== e1) begin
        mismatched++;
        $display("FAIL %s: count=%0d m0=%b m1=%b expected count=%0d m0=%b m1=%b",
                 it.ph, count, match0, match1, it.cnt, e0, e1);
      end
    end
  end

  task automatic wrByteT(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); #2;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); #2;
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  bit done = 1'b0;

  initial begin
    // R1: reset state observed by the scoreboard
    phase = "R1";
    idle(3);
    #2 rstN = 1'b1;
    idle(2);
    // R6: period register = 9, mid point = 4, buffering off
    phase = "R6";
    wrByteT(2'd2, 8'd9);
    wrByteT(2'd3, 8'd0);
    wrByteT(2'd0, 8'd4);
    wrByteT(2'd1, 8'd0);
    // R2: count, then hold
    phase = "R2";
    #2 runEn = 1'b1;
    idle(3);
    #2 runEn = 1'b0;
    idle(3);
    // R3/R4/R5: free run over two periods
    phase = "R3_R4_R5";
    #2 runEn = 1'b1;
    idle(22);
    // R7: direct load of compare 0 while running
    phase = "R7";
    wrByteT(2'd0, 8'd7);
    wrByteT(2'd1, 8'd0);
    idle(12);
    // R8: buffered write lands in shadow only
    phase = "R8";
    @(negedge clk); #2 bufEn = 1'b1;
    wrByteT(2'd0, 8'd2);
    wrByteT(2'd1, 8'd0);
    idle(6);
    // R9: after the wrap the shadow becomes active
    phase = "R9";
    idle(22);
    // R6: low byte only leaves the period unchanged
    phase = "R6";
    wrByteT(2'd2, 8'd3);
    idle(12);
    wrByteT(2'd3, 8'd0);
    phase = "R3_R5";
    idle(14);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule